// File: doc/BRIEF.md
# PCI Configuration Delayed-Transaction Target

This unit sits on the target side of a primary PCI bus. It answers Type 0 configuration reads and writes addressed to one function of a multi-function device. Every accepted access is handled as a delayed transaction. The first attempt is latched into a one-entry queue and told to retry. The unit then makes one 32-bit access on a simple internal request/acknowledge register bus and holds the result. When the initiator repeats the same request, it receives that held completion.

The PCI side is reduced to one cycle per attempt. A strobe presents IDSEL, the command, the low address bits, the active-low byte enables and the write data together. One clock later the unit reports one of three outcomes: ignored, claimed with retry, or claimed and completed. The internal bus carries the request, write enable, byte address, active-high byte enables and write data. It waits for a single-cycle acknowledge that also carries the read data.

Top module: `cfg_dt_target`

## Requirements
- R1: An attempt (`pci_valid`=1) is claimed only if `pci_idsel`=1, `pci_cmd` is 4'b1010 (configuration read) or 4'b1011 (configuration write), `pci_addr[1:0]`=00 and the function field matches. Any other attempt gets a response one clock later with `pci_rsp_vld`=1, `pci_claim`=0, `pci_retry`=0 and `pci_rdata`=0.
- R2: An attempt with `pci_addr[1:0]` not 00, such as a Type 1 cycle, is ignored. It leaves any pending entry untouched.
- R3: `pci_addr[10:8]` is the function number. Only the value 3'b001 is claimed, and every other value is ignored.
- R4: The internal byte address is 0x0000_1200 + 4 × `pci_addr[7:2]`. The internal byte enables are the bitwise inverse of `pci_cbe_n`, so bit i enables data byte i.
- R5: An attempt claimed while the queue is empty is latched and answered with `pci_claim`=1 and `pci_retry`=1. `ib_req` rises in the same cycle as that response. It holds with stable address, enables, direction and data until `ib_ack`.
- R6: Each latched entry produces exactly one internal access. For a write, `ib_we`=1 and `ib_wdata` is the latched write data.
- R7: A claimed attempt made while the internal access is still outstanding is answered with retry, even if it matches the entry.
- R8: Completion (`pci_claim`=1, `pci_retry`=0) is given only after the internal access has been acknowledged. Completion status is always normal.
- R9: A read completion returns on `pci_rdata` the word fetched from the internal bus. A write completion returns `pci_rdata`=0, because the completion data is discarded.
- R10: A claimed attempt whose command, register number, byte enables or (for writes) data differ from the entry is retried. The entry is left as it was, and the original request still completes later.
- R11: A completion frees the entry. The next claimed attempt is latched as a new request with its own internal access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pci_valid | input | 1 | One-cycle strobe marking a PCI attempt |
| pci_idsel | input | 1 | Configuration select for this device |
| pci_cmd | input | 4 | Bus command |
| pci_addr | input | 11 | Low address bits: function [10:8], register [7:2], type [1:0] |
| pci_cbe_n | input | 4 | Active-low byte enables of the data phase |
| pci_wdata | input | 32 | Write data of the attempt |
| pci_rsp_vld | output | 1 | Response to the previous cycle's attempt is valid |
| pci_claim | output | 1 | Attempt was claimed |
| pci_retry | output | 1 | Claimed attempt must be retried |
| pci_rdata | output | 32 | Read data on a read completion, else zero |
| ib_req | output | 1 | Internal access request |
| ib_we | output | 1 | Internal access is a write |
| ib_addr | output | 32 | Internal byte address |
| ib_be | output | 4 | Internal active-high byte enables |
| ib_wdata | output | 32 | Internal write data |
| ib_ack | input | 1 | Internal access acknowledge |
| ib_rdata | input | 32 | Internal read data, valid with ib_ack |

## Verification
Several properties are checked on every cycle:
- a claim never follows an attempt with the wrong command, type bits, IDSEL or function field;
- unclaimed responses never carry retry or data;
- the internal request stays stable until it is acknowledged and then drops;
- the internal address always lies word-aligned inside the 64-word window;
- no completion appears before an acknowledge has been seen for the current entry;
- write completions carry zero data.

Other behaviours need the bench's scenarios. These are the exact translated address and merged write bytes, the read data returned on the completing retry, and retry while the access is outstanding. They also include mismatching attempts that leave the entry intact, and freeing of the entry followed by a fresh latch.

// File: rtl/cfgdt_pkg.sv
// Shared encodings for the configuration delayed-transaction target.
// Assumes the simplified one-cycle-per-attempt PCI port of the top module.
package cfgdt_pkg;

    localparam logic [3:0] CMD_CFG_RD = 4'b1010;
    localparam logic [3:0] CMD_CFG_WR = 4'b1011;

    // Occupancy of the one-entry delayed request queue.
    typedef enum logic [1:0] {
        ENT_EMPTY = 2'd0,
        ENT_ISSUE = 2'd1,
        ENT_DONE  = 2'd2
    } ent_state_e;

    // Outcome of the attempt presented in the current cycle.
    typedef enum logic [1:0] {
        RSP_NONE     = 2'd0,
        RSP_IGNORE   = 2'd1,
        RSP_RETRY    = 2'd2,
        RSP_COMPLETE = 2'd3
    } rsp_kind_e;

endpackage

// File: rtl/cfgdt_decode.sv
// Address-phase decoder. Decides whether an attempt is a Type 0 configuration
// access to the selected function and extracts the DWORD register number.
// Assumes addr = {function, register, type} with the type field two bits wide.
module cfgdt_decode #(
    parameter int              REG_W    = 6,
    parameter int              FUNC_W   = 3,
    parameter logic [FUNC_W-1:0] FUNC_SEL = 3'b001
) (
    input  logic                      idsel,
    input  logic [3:0]                cmd,
    input  logic [REG_W+FUNC_W+1:0]   addr,
    output logic                      hit,
    output logic                      is_wr,
    output logic [REG_W-1:0]          reg_idx
);
    import cfgdt_pkg::*;

    localparam int ADDR_W = REG_W + FUNC_W + 2;

    logic is_rd;
    logic type0;
    logic func_ok;

    // Classify command, type bits and function number of the attempt.
    always_comb begin
        is_rd   = (cmd == CMD_CFG_RD);
        is_wr   = (cmd == CMD_CFG_WR);
        type0   = (addr[1:0] == 2'b00);
        func_ok = (addr[ADDR_W-1 -: FUNC_W] == FUNC_SEL);
        hit     = idsel && (is_rd || is_wr) && type0 && func_ok;
        reg_idx = addr[2 +: REG_W];
    end

endmodule

// File: rtl/cfgdt_entry.sv
// One-entry delayed transaction queue. Latches a claimed request when empty,
// compares later attempts against it, and decides the response kind.
// Assumes access_done pulses once while the entry is in ENT_ISSUE.
module cfgdt_entry #(
    parameter int REG_W  = 6,
    parameter int DATA_W = 32,
    parameter int BE_W   = DATA_W / 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        valid,
    input  logic                        hit,
    input  logic                        is_wr,
    input  logic [REG_W-1:0]            reg_idx,
    input  logic [BE_W-1:0]             be,
    input  logic [DATA_W-1:0]           wdata,
    input  logic                        access_done,
    output cfgdt_pkg::ent_state_e       state,
    output cfgdt_pkg::rsp_kind_e        kind,
    output logic                        ent_we,
    output logic [REG_W-1:0]            ent_reg,
    output logic [BE_W-1:0]             ent_be,
    output logic [DATA_W-1:0]           ent_wdata
);
    import cfgdt_pkg::*;

    ent_state_e state_q;
    logic       match;

    // Compare the current attempt with the latched entry.
    always_comb begin
        match = hit && (is_wr == ent_we) && (reg_idx == ent_reg) &&
                (be == ent_be) && (!is_wr || (wdata == ent_wdata));
    end

    // Pick the response for this cycle's attempt.
    always_comb begin
        kind = RSP_NONE;
        if (valid) begin
            if (!hit)
                kind = RSP_IGNORE;
            else if (state_q == ENT_DONE && match)
                kind = RSP_COMPLETE;
            else
                kind = RSP_RETRY;
        end
    end

    // Advance queue occupancy: latch, issue, hold completion, free.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ENT_EMPTY;
        end else begin
            unique case (state_q)
                ENT_EMPTY: if (valid && hit)       state_q <= ENT_ISSUE;
                ENT_ISSUE: if (access_done)        state_q <= ENT_DONE;
                ENT_DONE:  if (kind == RSP_COMPLETE) state_q <= ENT_EMPTY;
                default:                           state_q <= ENT_EMPTY;
            endcase
        end
    end

    // Capture the request fields when an empty queue accepts an attempt.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_we    <= 1'b0;
            ent_reg   <= '0;
            ent_be    <= '0;
            ent_wdata <= '0;
        end else if (state_q == ENT_EMPTY && valid && hit) begin
            ent_we    <= is_wr;
            ent_reg   <= reg_idx;
            ent_be    <= be;
            ent_wdata <= is_wr ? wdata : '0;
        end
    end

    assign state = state_q;

endmodule

// File: rtl/cfgdt_ibus.sv
// Internal bus master. Presents the latched entry as one access, maps the
// register number into the configuration window, and keeps the read word.
// Assumes the slave answers each request with a single-cycle ib_ack.
module cfgdt_ibus #(
    parameter int           REG_W   = 6,
    parameter int           DATA_W  = 32,
    parameter int           BE_W    = DATA_W / 8,
    parameter int           IB_AW   = 32,
    parameter logic [IB_AW-1:0] WIN_BASE = 32'h0000_1200
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                issue,
    input  logic                ent_we,
    input  logic [REG_W-1:0]    ent_reg,
    input  logic [BE_W-1:0]     ent_be,
    input  logic [DATA_W-1:0]   ent_wdata,
    input  logic                ib_ack,
    input  logic [DATA_W-1:0]   ib_rdata,
    output logic                ib_req,
    output logic                ib_we,
    output logic [IB_AW-1:0]    ib_addr,
    output logic [BE_W-1:0]     ib_be,
    output logic [DATA_W-1:0]   ib_wdata,
    output logic                access_done,
    output logic [DATA_W-1:0]   rd_word
);
    localparam int OFS_W = REG_W + $clog2(BE_W);
    localparam int WIN_BYTES = 1 << OFS_W;

    logic [OFS_W-1:0] byte_ofs;

    assign byte_ofs = {ent_reg, {($clog2(BE_W)){1'b0}}};

    // Window mapping: an aligned base needs only an OR, otherwise an adder.
    generate
        if ((WIN_BASE % WIN_BYTES) == 0) begin : g_or_map
            assign ib_addr = WIN_BASE | {{(IB_AW-OFS_W){1'b0}}, byte_ofs};
        end else begin : g_add_map
            assign ib_addr = WIN_BASE + {{(IB_AW-OFS_W){1'b0}}, byte_ofs};
        end
    endgenerate

    // Drive the request straight from the entry while it is being issued.
    always_comb begin
        ib_req      = issue;
        ib_we       = ent_we;
        ib_be       = ent_be;
        ib_wdata    = ent_wdata;
        access_done = issue && ib_ack;
    end

    // Keep the fetched word for reads; writes keep nothing.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_word <= '0;
        else if (access_done)
            rd_word <= ent_we ? '0 : ib_rdata;
    end

endmodule

// File: rtl/cfg_dt_target.sv
// Top level of the configuration delayed-transaction target. Decodes each
// attempt, runs it through the one-entry queue and the internal bus master,
// and registers the response so it appears one clock after the attempt.
// Assumes at most one attempt per cycle and attempts marked by pci_valid.
module cfg_dt_target #(
    parameter int               REG_W    = 6,
    parameter int               FUNC_W   = 3,
    parameter logic [FUNC_W-1:0] FUNC_SEL = 3'b001,
    parameter int               DATA_W   = 32,
    parameter int               IB_AW    = 32,
    parameter logic [IB_AW-1:0] WIN_BASE = 32'h0000_1200
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      pci_valid,
    input  logic                      pci_idsel,
    input  logic [3:0]                pci_cmd,
    input  logic [REG_W+FUNC_W+1:0]   pci_addr,
    input  logic [DATA_W/8-1:0]       pci_cbe_n,
    input  logic [DATA_W-1:0]         pci_wdata,
    output logic                      pci_rsp_vld,
    output logic                      pci_claim,
    output logic                      pci_retry,
    output logic [DATA_W-1:0]         pci_rdata,
    output logic                      ib_req,
    output logic                      ib_we,
    output logic [IB_AW-1:0]          ib_addr,
    output logic [DATA_W/8-1:0]       ib_be,
    output logic [DATA_W-1:0]         ib_wdata,
    input  logic                      ib_ack,
    input  logic [DATA_W-1:0]         ib_rdata
);
    import cfgdt_pkg::*;

    localparam int BE_W = DATA_W / 8;

    logic               dec_hit;
    logic               dec_wr;
    logic [REG_W-1:0]   dec_reg;
    ent_state_e         ent_state;
    rsp_kind_e          rsp_kind;
    logic               ent_we;
    logic [REG_W-1:0]   ent_reg;
    logic [BE_W-1:0]    ent_be;
    logic [DATA_W-1:0]  ent_wdata;
    logic               access_done;
    logic [DATA_W-1:0]  rd_word;

    cfgdt_decode #(
        .REG_W   (REG_W),
        .FUNC_W  (FUNC_W),
        .FUNC_SEL(FUNC_SEL)
    ) u_decode (
        .idsel  (pci_idsel),
        .cmd    (pci_cmd),
        .addr   (pci_addr),
        .hit    (dec_hit),
        .is_wr  (dec_wr),
        .reg_idx(dec_reg)
    );

    cfgdt_entry #(
        .REG_W (REG_W),
        .DATA_W(DATA_W),
        .BE_W  (BE_W)
    ) u_entry (
        .clk        (clk),
        .rst_n      (rst_n),
        .valid      (pci_valid),
        .hit        (dec_hit),
        .is_wr      (dec_wr),
        .reg_idx    (dec_reg),
        .be         (~pci_cbe_n),
        .wdata      (pci_wdata),
        .access_done(access_done),
        .state      (ent_state),
        .kind       (rsp_kind),
        .ent_we     (ent_we),
        .ent_reg    (ent_reg),
        .ent_be     (ent_be),
        .ent_wdata  (ent_wdata)
    );

    cfgdt_ibus #(
        .REG_W   (REG_W),
        .DATA_W  (DATA_W),
        .BE_W    (BE_W),
        .IB_AW   (IB_AW),
        .WIN_BASE(WIN_BASE)
    ) u_ibus (
        .clk        (clk),
        .rst_n      (rst_n),
        .issue      (ent_state == ENT_ISSUE),
        .ent_we     (ent_we),
        .ent_reg    (ent_reg),
        .ent_be     (ent_be),
        .ent_wdata  (ent_wdata),
        .ib_ack     (ib_ack),
        .ib_rdata   (ib_rdata),
        .ib_req     (ib_req),
        .ib_we      (ib_we),
        .ib_addr    (ib_addr),
        .ib_be      (ib_be),
        .ib_wdata   (ib_wdata),
        .access_done(access_done),
        .rd_word    (rd_word)
    );

    // Register the response to this cycle's attempt.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pci_rsp_vld <= 1'b0;
            pci_claim   <= 1'b0;
            pci_retry   <= 1'b0;
            pci_rdata   <= '0;
        end else begin
            pci_rsp_vld <= (rsp_kind != RSP_NONE);
            pci_claim   <= (rsp_kind == RSP_RETRY) || (rsp_kind == RSP_COMPLETE);
            pci_retry   <= (rsp_kind == RSP_RETRY);
            pci_rdata   <= (rsp_kind == RSP_COMPLETE && !ent_we) ? rd_word : '0;
        end
    end

endmodule

// File: rtl/cfgdt_checker.sv
// Property checker for cfg_dt_target, attached with bind below.
// Assumes it sees only the top-level ports of the target.
module cfgdt_checker #(
    parameter int               REG_W    = 6,
    parameter int               FUNC_W   = 3,
    parameter logic [FUNC_W-1:0] FUNC_SEL = 3'b001,
    parameter int               DATA_W   = 32,
    parameter int               IB_AW    = 32,
    parameter logic [IB_AW-1:0] WIN_BASE = 32'h0000_1200
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     pci_idsel,
    input logic [3:0]               pci_cmd,
    input logic [REG_W+FUNC_W+1:0]  pci_addr,
    input logic                     pci_rsp_vld,
    input logic                     pci_claim,
    input logic                     pci_retry,
    input logic [DATA_W-1:0]        pci_rdata,
    input logic                     ib_req,
    input logic                     ib_we,
    input logic [IB_AW-1:0]         ib_addr,
    input logic [DATA_W/8-1:0]      ib_be,
    input logic [DATA_W-1:0]        ib_wdata,
    input logic                     ib_ack
);
    localparam int ADDR_W   = REG_W + FUNC_W + 2;
    localparam int WIN_SIZE = (1 << REG_W) * (DATA_W / 8);

    logic completion;
    logic acked_q;

    assign completion = pci_rsp_vld && pci_claim && !pci_retry;

    // Remember whether the current entry's internal access was acknowledged.
    always_ff @(posedge clk) begin
        if (!rst_n)
            acked_q <= 1'b0;
        else if (completion)
            acked_q <= 1'b0;
        else if (ib_req && ib_ack)
            acked_q <= 1'b1;
    end

    // R1: a claim needs IDSEL and a configuration command in the attempt.
    a_r1_claim_qualified: assert property (@(posedge clk) disable iff (!rst_n)
        (pci_rsp_vld && pci_claim) |->
        ($past(pci_idsel) && ($past(pci_cmd) == 4'b1010 || $past(pci_cmd) == 4'b1011)));

    // R1: an unclaimed response carries neither retry nor data.
    a_r1_unclaimed_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (pci_rsp_vld && !pci_claim) |-> (!pci_retry && pci_rdata == '0));

    // R2: nonzero type bits are never claimed.
    a_r2_type1_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (pci_rsp_vld && $past(pci_addr[1:0]) != 2'b00) |-> !pci_claim);

    // R3: only the selected function number is claimed.
    a_r3_function_only: assert property (@(posedge clk) disable iff (!rst_n)
        (pci_rsp_vld && pci_claim) |-> ($past(pci_addr[ADDR_W-1 -: FUNC_W]) == FUNC_SEL));

    // R4: every internal address is word aligned inside the window.
    a_r4_addr_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        ib_req |-> (ib_addr[1:0] == 2'b00 && ib_addr >= WIN_BASE &&
                    ib_addr < WIN_BASE + WIN_SIZE));

    // R5: request held stable until acknowledged.
    a_r5_req_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (ib_req && !ib_ack) |=> (ib_req && $stable(ib_addr) && $stable(ib_we) &&
                                 $stable(ib_be) && $stable(ib_wdata)));

    // R6: one access per entry, so the request drops after its acknowledge.
    a_r6_single_access: assert property (@(posedge clk) disable iff (!rst_n)
        (ib_req && ib_ack) |=> !ib_req);

    // R8: completion only after the internal acknowledge.
    a_r8_done_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        completion |-> acked_q);

    // R9: write completions return zero data.
    a_r9_write_no_data: assert property (@(posedge clk) disable iff (!rst_n)
        (completion && $past(pci_cmd) == 4'b1011) |-> (pci_rdata == '0));

endmodule

bind cfg_dt_target cfgdt_checker #(
    .REG_W   (REG_W),
    .FUNC_W  (FUNC_W),
    .FUNC_SEL(FUNC_SEL),
    .DATA_W  (DATA_W),
    .IB_AW   (IB_AW),
    .WIN_BASE(WIN_BASE)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pci_idsel  (pci_idsel),
    .pci_cmd    (pci_cmd),
    .pci_addr   (pci_addr),
    .pci_rsp_vld(pci_rsp_vld),
    .pci_claim  (pci_claim),
    .pci_retry  (pci_retry),
    .pci_rdata  (pci_rdata),
    .ib_req     (ib_req),
    .ib_we      (ib_we),
    .ib_addr    (ib_addr),
    .ib_be      (ib_be),
    .ib_wdata   (ib_wdata),
    .ib_ack     (ib_ack)
);

// File: tb/sim_cfg_dt_target.sv
// Directed bench for cfg_dt_target: one task per scenario, each checking
// its own results against values worked out from the requirements.
module sim_cfg_dt_target;

    localparam logic [3:0] RD = 4'b1010;
    localparam logic [3:0] WR = 4'b1011;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pci_valid = 1'b0;
    logic        pci_idsel = 1'b0;
    logic [3:0]  pci_cmd = 4'h0;
    logic [10:0] pci_addr = '0;
    logic [3:0]  pci_cbe_n = 4'hF;
    logic [31:0] pci_wdata = '0;
    logic        pci_rsp_vld, pci_claim, pci_retry;
    logic [31:0] pci_rdata;
    logic        ib_req, ib_we;
    logic [31:0] ib_addr, ib_wdata;
    logic [3:0]  ib_be;
    logic        ib_ack = 1'b0;
    logic [31:0] ib_rdata = '0;

    int checks = 0;
    int fails = 0;
    bit finished = 0;

    // Internal bus model state.
    logic [31:0] mem [64];
    int          lat = 0;
    int          wait_cnt = 0;
    int          txn_cnt = 0;
    logic [31:0] last_addr, last_wdata;
    logic [3:0]  last_be;
    logic        last_we;

    // Captured response of the last attempt.
    logic        r_vld, r_claim, r_retry;
    logic [31:0] r_rdata;

    cfg_dt_target u0 (
        .clk(clk), .rst_n(rst_n), .pci_valid(pci_valid), .pci_idsel(pci_idsel),
        .pci_cmd(pci_cmd), .pci_addr(pci_addr), .pci_cbe_n(pci_cbe_n),
        .pci_wdata(pci_wdata), .pci_rsp_vld(pci_rsp_vld), .pci_claim(pci_claim),
        .pci_retry(pci_retry), .pci_rdata(pci_rdata), .ib_req(ib_req), .ib_we(ib_we),
        .ib_addr(ib_addr), .ib_be(ib_be), .ib_wdata(ib_wdata), .ib_ack(ib_ack),
        .ib_rdata(ib_rdata)
    );

    always #2 clk = ~clk;

    // Internal slave: acknowledges after lat idle cycles, one cycle wide.
    always @(negedge clk) begin
        if (ib_ack) begin
            ib_ack = 1'b0;
        end else if (ib_req) begin
            if (wait_cnt < lat) begin
                wait_cnt++;
            end else begin
                wait_cnt = 0;
                ib_ack = 1'b1;
                ib_rdata = mem[ib_addr[7:2]];
                if (ib_we)
                    for (int b = 0; b < 4; b++)
                        if (ib_be[b]) mem[ib_addr[7:2]][b*8 +: 8] = ib_wdata[b*8 +: 8];
                txn_cnt++;
                last_addr = ib_addr; last_we = ib_we;
                last_be = ib_be; last_wdata = ib_wdata;
            end
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    // One PCI attempt; the response is sampled one clock later.
    task automatic attempt(input logic idsel, input logic [3:0] cmd, input logic [2:0] fn,
                           input logic [5:0] rg, input logic [1:0] typ,
                           input logic [3:0] be_n, input logic [31:0] wd);
        @(negedge clk);
        pci_valid = 1'b1; pci_idsel = idsel; pci_cmd = cmd;
        pci_addr = {fn, rg, typ}; pci_cbe_n = be_n; pci_wdata = wd;
        @(negedge clk);
        pci_valid = 1'b0; pci_idsel = 1'b0;
        r_vld = pci_rsp_vld; r_claim = pci_claim; r_retry = pci_retry; r_rdata = pci_rdata;
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_retry(input string req);
        check(r_vld && r_claim && r_retry, req, {29'd0, r_vld, r_claim, r_retry}, 32'h7);
    endtask

    task automatic expect_ignored(input string req);
        check(r_vld && !r_claim && !r_retry && r_rdata == 0, req,
              {29'd0, r_vld, r_claim, r_retry}, 32'h4);
    endtask

    task automatic t_reset;
        check(!pci_rsp_vld && !pci_claim && !ib_req, "reset R1",
              {29'd0, pci_rsp_vld, pci_claim, ib_req}, 32'h0);
    endtask

    task automatic t_read;
        int base;
        lat = 4; base = txn_cnt;
        attempt(1, RD, 3'b001, 6'd5, 2'b00, 4'h0, 0);
        expect_retry("R5 first read attempt");
        check(ib_req && ib_addr == 32'h1214, "R4 read address", ib_addr, 32'h1214);
        check(ib_be == 4'hF && !ib_we, "R4 read enables", {27'd0, ib_we, ib_be}, 32'hF);
        attempt(1, RD, 3'b001, 6'd5, 2'b00, 4'h0, 0);
        expect_retry("R7 retry while pending");
        settle(8);
        attempt(1, RD, 3'b001, 6'd5, 2'b00, 4'h0, 0);
        check(r_vld && r_claim && !r_retry, "R8 read completes", {30'd0, r_claim, r_retry}, 32'h2);
        check(r_rdata == 32'hC0DE_0005, "R9 read data", r_rdata, 32'hC0DE_0005);
        check(txn_cnt == base + 1, "R6 one access for read", txn_cnt, base + 1);
    endtask

    task automatic t_write;
        int base;
        lat = 0; base = txn_cnt;
        attempt(1, WR, 3'b001, 6'd63, 2'b00, 4'b1010, 32'h1122_3344);
        expect_retry("R5 first write attempt");
        settle(4);
        check(last_addr == 32'h12FC, "R4 top register address", last_addr, 32'h12FC);
        check(last_we && last_be == 4'b0101, "R4 write enables", {27'd0, last_we, last_be}, 32'h15);
        check(last_wdata == 32'h1122_3344, "R6 write data", last_wdata, 32'h1122_3344);
        attempt(1, WR, 3'b001, 6'd63, 2'b00, 4'b1010, 32'h1122_3344);
        check(r_claim && !r_retry, "R8 write completes", {30'd0, r_claim, r_retry}, 32'h2);
        check(r_rdata == 0, "R9 write completion data", r_rdata, 0);
        check(txn_cnt == base + 1, "R6 one access for write", txn_cnt, base + 1);
        attempt(1, RD, 3'b001, 6'd63, 2'b00, 4'h0, 0);
        expect_retry("R11 next request latched");
        settle(4);
        attempt(1, RD, 3'b001, 6'd63, 2'b00, 4'h0, 0);
        check(r_rdata == 32'hC022_0044, "R6 merged bytes", r_rdata, 32'hC022_0044);
    endtask

    task automatic t_ignore;
        int base;
        base = txn_cnt;
        attempt(1, RD, 3'b001, 6'd1, 2'b01, 4'h0, 0);
        expect_ignored("R2 type1 ignored");
        attempt(1, RD, 3'b010, 6'd1, 2'b00, 4'h0, 0);
        expect_ignored("R3 function 2 ignored");
        attempt(1, WR, 3'b000, 6'd1, 2'b00, 4'h0, 0);
        expect_ignored("R3 function 0 ignored");
        attempt(1, 4'b0110, 3'b001, 6'd1, 2'b00, 4'h0, 0);
        expect_ignored("R1 memory read not claimed");
        attempt(0, RD, 3'b001, 6'd1, 2'b00, 4'h0, 0);
        expect_ignored("R1 idsel low not claimed");
        settle(3);
        check(txn_cnt == base && !ib_req, "R1 no access for ignored", txn_cnt, base);
    endtask

    task automatic t_mismatch;
        int base;
        lat = 1; base = txn_cnt;
        attempt(1, RD, 3'b001, 6'd3, 2'b00, 4'h0, 0);
        expect_retry("R5 latch read reg3");
        settle(5);
        attempt(1, RD, 3'b001, 6'd4, 2'b00, 4'h0, 0);
        expect_retry("R10 other register retried");
        attempt(1, RD, 3'b001, 6'd3, 2'b00, 4'h1, 0);
        expect_retry("R10 other byte enables retried");
        attempt(1, WR, 3'b001, 6'd3, 2'b00, 4'h0, 0);
        expect_retry("R10 other command retried");
        attempt(1, RD, 3'b001, 6'd3, 2'b11, 4'h0, 0);
        expect_ignored("R2 type1 during pending");
        check(txn_cnt == base + 1, "R10 no extra access", txn_cnt, base + 1);
        attempt(1, RD, 3'b001, 6'd3, 2'b00, 4'h0, 0);
        check(r_claim && !r_retry && r_rdata == 32'hC0DE_0003, "R10 original completes",
              r_rdata, 32'hC0DE_0003);
        attempt(1, WR, 3'b001, 6'd7, 2'b00, 4'h0, 32'hAAAA_0007);
        expect_retry("R5 latch write reg7");
        settle(5);
        attempt(1, WR, 3'b001, 6'd7, 2'b00, 4'h0, 32'hBBBB_0007);
        expect_retry("R10 other write data retried");
        attempt(1, WR, 3'b001, 6'd7, 2'b00, 4'h0, 32'hAAAA_0007);
        check(r_claim && !r_retry, "R10 matching write completes", {30'd0, r_claim, r_retry}, 32'h2);
        check(mem[7] == 32'hAAAA_0007, "R6 latched data written", mem[7], 32'hAAAA_0007);
        check(txn_cnt == base + 2, "R11 one access per entry", txn_cnt, base + 2);
    endtask

    task automatic finish_run;
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    endtask

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = 32'hC0DE_0000 | i;
        settle(3);
        t_reset;
        @(negedge clk); rst_n = 1'b1;
        settle(2);
        t_read;
        t_write;
        t_ignore;
        t_mismatch;
        settle(4);
        finish_run;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: run did not finish");
        finish_run;
    end

endmodule